// File: doc/BRIEF.md
# Double-Buffered Channel Register Bank

This block sits behind a serial command receiver and holds the digital state of a bank of converter channels. Every channel owns a staging register, an active register whose value drives the converter, and a power flag. The receiver hands over one decoded command at a time: an operation code, a channel address, a 16-bit data word and a one-cycle valid strobe. The bank applies the command on the clock edge that samples the strobe.

The operations are: stage a new code, commit a staged code, stage a code and then commit every channel at once, load a code straight into both registers, put a channel to sleep, and do nothing. A single address value reaches all channels at once. The converter resolution is a parameter. The code is taken from the upper bits of the data word, and the lower bits are discarded. An active-low asynchronous clear and the reset both return the bank to zero codes with every channel powered. If a command uses an undefined operation or address, nothing changes and a one-cycle error pulse is raised.

Top module: `chan_reg_bank`

## Requirements
- R1: While reset is asserted and afterwards, until a command takes effect, every active code is zero, every power flag is 1 and the error pulse is 0.
- R2: Operation 4'h0 loads the code into the staging register of the addressed channel only. No active code and no power flag changes.
- R3: Operation 4'h1 copies the staging register of the addressed channel into its active register and sets its power flag.
- R4: Operation 4'h2 first stages the code into the addressed channel. It then copies the staging register of every channel into its active register and sets all power flags. The addressed channel's active code therefore equals the new code.
- R5: Operation 4'h3 writes the code into both registers of the addressed channel and sets its power flag.
- R6: Operation 4'h4 clears the power flag of the addressed channel. The data word is ignored, and both registers keep their values, which a later 4'h1 makes visible.
- R7: Operation 4'hF changes nothing and raises no error, whatever its address.
- R8: Address values 0 to NUM_CH-1 select a single channel, and address 4'hF selects every channel for each operation.
- R9: For operation codes 4'h5 to 4'hE, and for any operation other than 4'hF with an address from NUM_CH to 4'hE, nothing changes. The error pulse is 1 for exactly the one cycle after the command is sampled.
- R10: A low level on clr_n immediately, without waiting for a clock edge, zeroes every staging and active register, sets every power flag and clears the error pulse.
- R11: The channel code is data_i[15 -: CODE_W]. The lower DATA_W-CODE_W bits are discarded.
- R12: While cmd_vld_i is low, no output changes, whatever the command inputs carry.
- R13: A command takes effect on the rising clock edge that samples cmd_vld_i high, so the outputs show it after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n | input | 1 | Active-low asynchronous clear of all channel state |
| cmd_vld_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Operation code |
| cmd_addr_i | input | ADDR_W (4) | Channel address, all ones for every channel |
| cmd_data_i | input | DATA_W (16) | Data word, with the code in its upper bits |
| act_codes_o | output | NUM_CH*CODE_W (128) | Active codes, channel n at bits n*CODE_W upward |
| pwr_up_o | output | NUM_CH (8) | Power flag per channel, 1 = powered |
| err_o | output | 1 | One-cycle pulse after an undefined command |

## Verification
The stage-then-commit-all operation makes two functions meet in one edge. The addressed channel's staging write and the global copy from staging to active both happen at that edge, so the addressed channel must expose the new code and not the previously staged one. The bench provokes this with random sequences in which a channel's staging register already holds a value different from the incoming code. The bench's model performs the stage before the copy, and every output is compared after the edge. A second meeting point, the asynchronous clear arriving while channels hold codes, is judged between clock edges and then by a broadcast commit, which shows that the staging registers were cleared as well.

// File: rtl/chbank_pkg.sv
package chbank_pkg;
   localparam int unsigned OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_STAGE      = 4'h0,
      OP_COMMIT     = 4'h1,
      OP_STAGE_ALL  = 4'h2,
      OP_LOAD_BOTH  = 4'h3,
      OP_SLEEP      = 4'h4,
      OP_IDLE       = 4'hF
   } op_e;
endpackage

// File: rtl/chbank_decode.sv
module chbank_decode
   import chbank_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              vld_i,
   input  logic [OPC_W-1:0]  op_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] st_we_o,
   output logic [NUM_CH-1:0] upd_o,
   output logic [NUM_CH-1:0] pd_o,
   output logic              bad_o
);
   localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

   logic              addr_all;
   logic              addr_ok;
   logic              op_ok;
   logic [NUM_CH-1:0] sel;

   assign addr_all = (addr_i == ADDR_ALL);
   assign addr_ok  = addr_all || (addr_i < ADDR_W'(NUM_CH));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign sel[g] = addr_all || (addr_i == ADDR_W'(g));
   end

   always_comb begin
      st_we_o = '0;
      upd_o   = '0;
      pd_o    = '0;
      op_ok   = 1'b1;
      case (op_i)
         OP_STAGE:     st_we_o = sel;
         OP_COMMIT:    upd_o   = sel;
         OP_STAGE_ALL: begin
            st_we_o = sel;
            upd_o   = '1;
         end
         OP_LOAD_BOTH: begin
            st_we_o = sel;
            upd_o   = sel;
         end
         OP_SLEEP:     pd_o    = sel;
         OP_IDLE:      ;
         default:      op_ok   = 1'b0;
      endcase
      bad_o = vld_i && (!op_ok || (op_i != OP_IDLE && !addr_ok));
      if (!vld_i || bad_o || op_i == OP_IDLE) begin
         st_we_o = '0;
         upd_o   = '0;
         pd_o    = '0;
      end
   end
endmodule

// File: rtl/chbank_slot.sv
module chbank_slot #(
   parameter int unsigned CODE_W = 16
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              st_we_i,
   input  logic              upd_i,
   input  logic              pd_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] act_q,
   output logic              pwr_q
);
   logic [CODE_W-1:0] stage_q;
   logic [CODE_W-1:0] stage_nxt;

   assign stage_nxt = st_we_i ? code_i : stage_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         stage_q <= '0;
         act_q   <= '0;
         pwr_q   <= 1'b1;
      end else begin
         stage_q <= stage_nxt;
         if (upd_i) begin
            act_q <= stage_nxt;
            pwr_q <= 1'b1;
         end else if (pd_i) begin
            pwr_q <= 1'b0;
         end
      end
   end

   AST_UPD_POWERS: assert property (@(posedge clk) disable iff (!arst_n)
      upd_i |=> pwr_q) else $error("update left channel asleep"); // R3

   AST_PD_SLEEPS: assert property (@(posedge clk) disable iff (!arst_n)
      (pd_i && !upd_i) |=> (!pwr_q && $stable(act_q))) else $error("sleep failed"); // R6

   AST_HOLD_ACT: assert property (@(posedge clk) disable iff (!arst_n)
      !upd_i |=> $stable(act_q)) else $error("active code moved without update"); // R2

   AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!arst_n)
      (st_we_i && upd_i) |=> (act_q == $past(code_i))) else $error("new code not active"); // R5
endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
   import chbank_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CODE_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_n,
   input  logic                     cmd_vld_i,
   input  logic [OPC_W-1:0]         cmd_op_i,
   input  logic [ADDR_W-1:0]        cmd_addr_i,
   input  logic [DATA_W-1:0]        cmd_data_i,
   output logic [NUM_CH*CODE_W-1:0] act_codes_o,
   output logic [NUM_CH-1:0]        pwr_up_o,
   output logic                     err_o
);
   localparam int unsigned DROP_W = DATA_W - CODE_W;

   if (CODE_W == 0 || CODE_W > DATA_W) begin : g_bad_code_w
      $error("CODE_W must lie in 1..DATA_W");
   end
   if (NUM_CH < 1 || NUM_CH >= (1 << ADDR_W)) begin : g_bad_num_ch
      $error("NUM_CH must leave the all-ones address free");
   end

   logic              arst_n;
   logic [CODE_W-1:0] code;
   logic [NUM_CH-1:0] st_we;
   logic [NUM_CH-1:0] upd;
   logic [NUM_CH-1:0] pd;
   logic              bad;

   assign arst_n = rst_n & clr_n;

   if (DROP_W == 0) begin : g_code_full
      assign code = cmd_data_i;
   end else begin : g_code_msb
      assign code = cmd_data_i[DATA_W-1 -: CODE_W];
   end

   chbank_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) i_decode (
      .vld_i   (cmd_vld_i),
      .op_i    (cmd_op_i),
      .addr_i  (cmd_addr_i),
      .st_we_o (st_we),
      .upd_o   (upd),
      .pd_o    (pd),
      .bad_o   (bad)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      chbank_slot #(
         .CODE_W (CODE_W)
      ) i_slot (
         .clk     (clk),
         .arst_n  (arst_n),
         .st_we_i (st_we[g]),
         .upd_i   (upd[g]),
         .pd_i    (pd[g]),
         .code_i  (code),
         .act_q   (act_codes_o[g*CODE_W +: CODE_W]),
         .pwr_q   (pwr_up_o[g])
      );
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) err_o <= 1'b0;
      else         err_o <= bad;
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
      !cmd_vld_i |=> ($stable(act_codes_o) && $stable(pwr_up_o))) else $error("change without strobe"); // R12

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
      err_o |-> $past(cmd_vld_i)) else $error("error pulse without command"); // R9

   AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!arst_n)
      err_o |-> ($stable(act_codes_o) && $stable(pwr_up_o))) else $error("undefined command changed state"); // R9

   AST_CLEAR_ZERO: assert property (@(posedge clk)
      !clr_n |-> (act_codes_o == '0 && pwr_up_o == '1 && !err_o)) else $error("clear incomplete"); // R10
endmodule

// File: tb/test_chan_reg_bank.sv
module test_chan_reg_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DW  = 16;
   localparam int CW  = 12;
   localparam int AW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_n = 1'b1;
   logic          cmd_vld = 1'b0;
   logic [3:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic [NCH*CW-1:0] act_codes;
   logic [NCH-1:0]    pwr_up;
   logic              err;

   int n_run = 0;
   int n_fail = 0;

   logic [CW-1:0]  m_stage [NCH];
   logic [CW-1:0]  m_act   [NCH];
   logic [NCH-1:0] m_pwr;
   logic           m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_reg_bank #(
      .NUM_CH (NCH), .DATA_W (DW), .CODE_W (CW), .ADDR_W (AW)
   ) i_chan_reg_bank (
      .clk (clk), .rst_n (rst_n), .clr_n (clr_n),
      .cmd_vld_i (cmd_vld), .cmd_op_i (cmd_op), .cmd_addr_i (cmd_addr),
      .cmd_data_i (cmd_data),
      .act_codes_o (act_codes), .pwr_up_o (pwr_up), .err_o (err)
   );

   function automatic bit op_defined(logic [3:0] op);
      return op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hF};
   endfunction

   function automatic string req_tag(logic [3:0] op, logic [AW-1:0] a, bit v);
      if (!v) return "R12";
      if (!op_defined(op)) return "R9";
      if (op == 4'hF) return "R7";
      if (a == 4'hF) return "R8";
      if (a >= NCH) return "R9";
      case (op)
         4'h0: return "R2";
         4'h1: return "R3";
         4'h2: return "R4";
         4'h3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NCH; i++) begin
         m_stage[i] = '0;
         m_act[i]   = '0;
      end
      m_pwr = '1;
      m_err = 1'b0;
   endtask

   // R11: the code is the upper CW bits of the data word
   task automatic model_apply(logic [3:0] op, logic [AW-1:0] a, logic [DW-1:0] d, bit v);
      logic [CW-1:0] code;
      bit bad;
      code = d[DW-1 -: CW];
      bad  = v && (!op_defined(op) || (op != 4'hF && a != 4'hF && a >= NCH));
      m_err = bad;
      if (!v || bad || op == 4'hF) return;
      for (int i = 0; i < NCH; i++) begin
         if (a == 4'hF || a == AW'(i)) begin
            case (op)
               4'h0, 4'h2: m_stage[i] = code;
               4'h1: begin m_act[i] = m_stage[i]; m_pwr[i] = 1'b1; end
               4'h3: begin m_stage[i] = code; m_act[i] = code; m_pwr[i] = 1'b1; end
               4'h4: m_pwr[i] = 1'b0;
               default: ;
            endcase
         end
      end
      if (op == 4'h2) begin
         for (int i = 0; i < NCH; i++) m_act[i] = m_stage[i];
         m_pwr = '1;
      end
   endtask

   task automatic check_all(string tag);
      logic [NCH*CW-1:0] exp_codes;
      for (int i = 0; i < NCH; i++) exp_codes[i*CW +: CW] = m_act[i];
      n_run++;
      if (act_codes !== exp_codes || pwr_up !== m_pwr || err !== m_err) begin
         n_fail++;
         $display("FAIL %s actual act=%h pwr=%b err=%b expected act=%h pwr=%b err=%b",
                  tag, act_codes, pwr_up, err, exp_codes, m_pwr, m_err);
      end
   endtask

   // R13: inputs driven at a falling edge, result observed at the next falling edge
   task automatic issue(logic [3:0] op, logic [AW-1:0] a, logic [DW-1:0] d, bit v);
      @(negedge clk);
      cmd_vld = v; cmd_op = op; cmd_addr = a; cmd_data = d;
      model_apply(op, a, d, v);
      @(negedge clk);
      cmd_vld = 1'b0;
      check_all(req_tag(op, a, v));
      m_err = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] ops [6];
      void'($urandom(32'd1357));
      ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hF};
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      issue(4'h0, 4'd2, 16'hABC7, 1'b1);   // R2 stage only, low nibble dropped (R11)
      issue(4'h1, 4'd2, 16'h0000, 1'b1);   // R3 commit shows 0xABC
      issue(4'h4, 4'd2, 16'hFFFF, 1'b1);   // R6 sleep, data ignored
      issue(4'h1, 4'd2, 16'h1234, 1'b1);   // R6 registers kept, R3 wake
      issue(4'h0, 4'hF, 16'h5550, 1'b1);   // R8 broadcast stage
      issue(4'h0, 4'd5, 16'h9990, 1'b1);   // R2
      issue(4'h2, 4'd5, 16'h7770, 1'b1);   // R4 new code beats old staged value
      issue(4'h3, 4'd7, 16'hFFF0, 1'b1);   // R5
      issue(4'h4, 4'hF, 16'h0000, 1'b1);   // R8 all asleep
      issue(4'h3, 4'hF, 16'h8001, 1'b1);   // R8 load both everywhere
      issue(4'h7, 4'd1, 16'h4440, 1'b1);   // R9 undefined op
      issue(4'h3, 4'd9, 16'h4440, 1'b1);   // R9 undefined address
      issue(4'hF, 4'd9, 16'h4440, 1'b1);   // R7 idle, no error
      issue(4'h3, 4'd0, 16'h2220, 1'b0);   // R12 no strobe

      for (int k = 0; k < 400; k++) begin
         logic [3:0] op;
         logic [AW-1:0] a;
         int unsigned r;
         r = $urandom % 16;
         op = (r < 12) ? ops[r % 6] : 4'($urandom);
         r = $urandom % 10;
         a = (r < 8) ? AW'(r) : (r == 8) ? 4'hF : AW'($urandom);
         issue(op, a, 16'($urandom), ($urandom % 8) != 0);
      end

      // R10 asynchronous clear, seen between edges
      issue(4'h3, 4'hF, 16'hC3C0, 1'b1);
      issue(4'h0, 4'hF, 16'h5A50, 1'b1);
      @(negedge clk);
      #(CLK_PERIOD/4);
      clr_n = 1'b0;
      #1;
      model_reset();
      check_all("R10");
      @(negedge clk);
      clr_n = 1'b1;
      issue(4'h1, 4'hF, 16'h0000, 1'b1);   // R10 staging cleared too

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule